// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause-22 management transactions toward an external PHY over a two-wire interface: a management clock (MDC) and a bidirectional data line, which is brought out as a separate output, output enable and input. A host reaches it through a word-addressed register port with a write strobe and a combinational read path. To run a transaction, the host sets the clock divisor and the preamble option, the PHY address, the register address and, for a write, the data word. It then sets a command bit and polls the busy flag. When busy drops it reads the captured word.

Each frame is built in the order the line protocol requires. It starts with an optional run of 32 ones. Then come the start pattern `01`, the opcode (`10` for read, `01` for write), the five PHY address bits, the five register address bits, a two-bit turnaround, and sixteen data bits sent MSB first. Data is changed on the falling edge of MDC and sampled on its rising edge. A scan command repeats reads for as long as its bit stays set, and each result updates a link-fail flag.

Top module: `mdio_mgmt_ctrl`

Register map (word address on `reg_addr`):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | bits 7:0 divisor, with bit 0 always read as 0; bit 8 suppresses the preamble |
| 1 | read/write | command: bit 0 scan, bit 1 read, bit 2 write |
| 2 | read/write | bits 4:0 PHY address; bits 12:8 register address |
| 3 | read/write | bits 15:0 data for a write |
| 4 | read only | bits 15:0 last word captured by a read or scan |
| 5 | read only | bit 0 link fail, bit 1 busy, bit 2 invalid |

## Requirements
- R1: After reset every register reads 0, MDC is low, the data output enable is low and the status register reads 0.
- R2: Divisor bit 0 always reads back as 0. MDC high and low phases each last divisor/2 clock cycles, so a full MDC period is the even divisor in clock cycles. A divisor of 0 behaves as 2.
- R3: A read sends 32 ones, then `01`, opcode `10`, PHY address and register address, each MSB first. The line is released from the first turnaround bit to the end of the frame. Sixteen bits sampled at MDC rising edges, MSB first, then appear at address 4.
- R4: A write sends the same header with opcode `01`, then turnaround `10` and the sixteen data bits MSB first. The line is driven for the whole frame.
- R5: With mode bit 8 set, the 32 preamble ones are omitted and the frame begins with `01`.
- R6: Status bit 1 (busy) reads 1 from the cycle after a command write that starts a frame until that frame ends.
- R7: A frame starts only when a command bit goes from 0 to 1 while the controller is idle. Writing 0, rewriting a bit that is already set, or setting a new bit while busy starts nothing.
- R8: When several command bits rise together, write wins over read and read wins over scan. The losing bits start nothing.
- R9: While command bit 0 stays set, scan reads repeat back to back. Invalid (status bit 2) reads 1 from the scan start until the first scan frame ends. Link fail (status bit 0) is the inverse of bit 2 of the latest scan result. Clearing bit 0 stops the scan after the current frame.
- R10: Whenever no frame is running, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data in |

## Verification
Most wrong internal states show up as a captured frame that differs from the expected bit list. A bit index that skips or repeats, a wrong opcode or a wrong turnaround each appear within one MDC period of the faulty bit. A wrong divide shows in the measured MDC period of the very first bit. Faults in the capture shift or in edge detection only show at the end of the frame, in the read-back word or the busy flag, or as extra MDC edges after a command that should have been ignored. Scan faults appear one frame late, in the invalid and link-fail flags.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_SCAN  = 2'd3
  } mdio_op_e;

  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  // register word addresses
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_ADR  = 3'd2;
  localparam logic [2:0] A_WD   = 3'd3;
  localparam logic [2:0] A_RD   = 3'd4;
  localparam logic [2:0] A_ST   = 3'd5;

  // command bit positions
  localparam int CMD_SCAN  = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRITE = 2;

  localparam int NOPRE_BIT   = 8;
  localparam int RG_FIELD_LO = 8;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_div,
  output logic              mdc,
  output logic              rise_stb,
  output logic              fall_stb
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic [HALF_W-1:0] half_eff;
  logic              tick;

  always_comb begin
    half_eff = (half_div == '0) ? HALF_W'(1) : half_div;
    tick     = run && (cnt_q >= (half_eff - HALF_W'(1)));
    cnt_d    = '0;
    mdc_d    = 1'b0;
    if (run) begin
      cnt_d = tick ? '0 : cnt_q + HALF_W'(1);
      mdc_d = tick ? ~mdc_q : mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;

  // R10: clock parks low once the engine stops
  p_mdc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

  // R2: clock only rises while a frame runs
  p_rise_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(run));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_op_e          op,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              no_pre,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] shift_word,
  output logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int FRAME_W = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int TA_POS  = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DAT_POS = TA_POS + 2;
  localparam int LAST    = FRAME_W - 1;

  logic               act_q, act_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic               rd_q, rd_d;
  logic [DATA_W-1:0]  shf_q, shf_d;
  logic [DATA_W-1:0]  rdat_q, rdat_d;
  logic               is_last;
  logic [1:0]         opc, ta;
  logic [DATA_W-1:0]  dat;

  always_comb begin
    is_last = (idx_q == IDX_W'(LAST));
    done    = act_q && fall_stb && is_last;
    opc     = (op == OP_WRITE) ? 2'b01 : 2'b10;
    ta      = (op == OP_WRITE) ? 2'b10 : 2'b11;
    dat     = (op == OP_WRITE) ? wdata : '1;
    act_d   = act_q;
    idx_d   = idx_q;
    frm_d   = frm_q;
    rd_d    = rd_q;
    shf_d   = shf_q;
    rdat_d  = rdat_q;
    if (start && !act_q) begin
      act_d = 1'b1;
      idx_d = no_pre ? IDX_W'(PRE_LEN) : '0;
      frm_d = {{PRE_LEN{1'b1}}, 2'b01, opc, phy, regad, ta, dat};
      rd_d  = (op != OP_WRITE);
    end else if (act_q) begin
      if (rise_stb && rd_q && (idx_q >= IDX_W'(DAT_POS)))
        shf_d = {shf_q[DATA_W-2:0], mdio_in};
      if (fall_stb) begin
        if (is_last) begin
          act_d = 1'b0;
          if (rd_q) rdat_d = shf_q;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      frm_q  <= '0;
      rd_q   <= 1'b0;
      shf_q  <= '0;
      rdat_q <= '0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      frm_q  <= frm_d;
      rd_q   <= rd_d;
      shf_q  <= shf_d;
      rdat_q <= rdat_d;
    end
  end

  assign active     = act_q;
  assign shift_word = shf_q;
  assign rd_word    = rdat_q;
  assign mdio_o     = act_q ? frm_q[IDX_W'(LAST) - idx_q] : 1'b0;
  assign mdio_oe    = act_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));

  // R10: line not driven between frames
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !mdio_oe);

  // R6: a running frame only ends through its last falling edge
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !done |=> act_q);

  // R3: once released during a read, the line stays released
  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && rd_q && $past(act_q) && !$past(mdio_oe) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  localparam int HALF_W = DIV_W - 1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic              nopre_q, nopre_d;
  logic [2:0]        cmd_q, cmd_d, prev_q;
  logic [PHY_W-1:0]  phy_q, phy_d;
  logic [REG_W-1:0]  rg_q, rg_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              scan_run_q, scan_run_d;
  logic              cur_scan_q, cur_scan_d;
  logic              invalid_q, invalid_d;
  logic              linkf_q, linkf_d;

  logic              eng_act, eng_done;
  logic [DATA_W-1:0] eng_shift, eng_rword;
  logic              rise_stb, fall_stb;
  logic [2:0]        cmd_rise;
  logic              idle, st_wr, st_rd, st_sc, start, busy;
  mdio_op_e          op;
  logic              wr_sel;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[31:16];

  always_comb begin
    cmd_rise = cmd_q & ~prev_q;
    idle     = !eng_act;
    st_wr    = idle && cmd_rise[CMD_WRITE];
    st_rd    = idle && !cmd_rise[CMD_WRITE] && cmd_rise[CMD_READ];
    st_sc    = idle && !cmd_rise[CMD_WRITE] && !cmd_rise[CMD_READ] &&
               (cmd_rise[CMD_SCAN] || (scan_run_q && cmd_q[CMD_SCAN]));
    start    = st_wr || st_rd || st_sc;
    op       = st_wr ? OP_WRITE : (st_rd ? OP_READ : (st_sc ? OP_SCAN : OP_NONE));
    busy     = eng_act || start;
  end

  always_comb begin
    div_d      = div_q;
    nopre_d    = nopre_q;
    cmd_d      = cmd_q;
    phy_d      = phy_q;
    rg_d       = rg_q;
    wd_d       = wd_q;
    wr_sel     = reg_we;
    if (wr_sel) begin
      case (reg_addr)
        A_MODE: begin
          div_d   = reg_wdata[DIV_W-1:0] & ~DIV_W'(1);
          nopre_d = reg_wdata[NOPRE_BIT];
        end
        A_CMD:  cmd_d = reg_wdata[2:0];
        A_ADR: begin
          phy_d = reg_wdata[PHY_W-1:0];
          rg_d  = reg_wdata[RG_FIELD_LO +: REG_W];
        end
        A_WD:   wd_d = reg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
    scan_run_d = scan_run_q;
    if (st_sc) scan_run_d = 1'b1;
    else if (!cmd_q[CMD_SCAN]) scan_run_d = 1'b0;
    cur_scan_d = start ? st_sc : cur_scan_q;
    invalid_d  = invalid_q;
    linkf_d    = linkf_q;
    if (st_sc && !scan_run_q) invalid_d = 1'b1;
    else if (eng_done && cur_scan_q) invalid_d = 1'b0;
    if (eng_done && cur_scan_q) linkf_d = ~eng_shift[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      nopre_q    <= 1'b0;
      cmd_q      <= '0;
      prev_q     <= '0;
      phy_q      <= '0;
      rg_q       <= '0;
      wd_q       <= '0;
      scan_run_q <= 1'b0;
      cur_scan_q <= 1'b0;
      invalid_q  <= 1'b0;
      linkf_q    <= 1'b0;
    end else begin
      div_q      <= div_d;
      nopre_q    <= nopre_d;
      cmd_q      <= cmd_d;
      prev_q     <= cmd_q;
      phy_q      <= phy_d;
      rg_q       <= rg_d;
      wd_q       <= wd_d;
      scan_run_q <= scan_run_d;
      cur_scan_q <= cur_scan_d;
      invalid_q  <= invalid_d;
      linkf_q    <= linkf_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[DIV_W-1:0]  = div_q;
        reg_rdata[NOPRE_BIT]  = nopre_q;
      end
      A_CMD:  reg_rdata[2:0] = cmd_q;
      A_ADR: begin
        reg_rdata[PHY_W-1:0]           = phy_q;
        reg_rdata[RG_FIELD_LO +: REG_W] = rg_q;
      end
      A_WD:   reg_rdata[DATA_W-1:0] = wd_q;
      A_RD:   reg_rdata[DATA_W-1:0] = eng_rword;
      A_ST:   reg_rdata[2:0] = {invalid_q, busy, linkf_q};
      default: ;
    endcase
  end

  mdio_clk_div #(.HALF_W(HALF_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_act),
    .half_div (div_q[DIV_W-1:1]),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .phy        (phy_q),
    .regad      (rg_q),
    .wdata      (wd_q),
    .no_pre     (nopre_q),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_in    (mdio_in),
    .active     (eng_act),
    .done       (eng_done),
    .shift_word (eng_shift),
    .rd_word    (eng_rword),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  // R2: divisor low bit never kept after a mode write
  p_div_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == A_MODE) |=> !div_q[0]);

  // R6: a starting command write shows busy on the next cycle
  p_busy_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == A_CMD) && (reg_wdata[2:0] != 3'b000) &&
    (cmd_q == 3'b000) && !eng_act |=> busy);

  // R7: clearing the command while idle starts nothing
  p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == A_CMD) && (reg_wdata[2:0] == 3'b000) && !busy &&
    !scan_run_q |=> !busy);

  // R9: invalid only drops when a scan frame ends
  p_invalid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invalid_q) |-> $past(eng_done));

  // R8: at most one start request at a time
  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_wr, st_rd, st_sc}));

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_in;

  int errs;
  int checks;
  logic [15:0] phy_val;
  logic [1:0]  cap [0:4095];
  int          cap_n;
  time         last_rise;
  time         per;
  int          rel;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bit capture and PHY model
  always @(posedge mdc) begin
    #1;
    if (cap_n < 4096) cap[cap_n] = mdio_oe ? {1'b0, mdio_o} : 2'b10;
    cap_n = cap_n + 1;
    per = $time - last_rise;
    last_rise = $time;
    if (mdio_oe) begin
      rel = 0;
      mdio_in = 1'b1;
    end else begin
      rel = rel + 1;
      if (rel >= 2 && rel <= 17) mdio_in = phy_val[17-rel];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 30000; i++) begin
      reg_read(3'd5, s);
      if (!s[1]) return;
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compare captured bits from base against the expected frame
  task automatic chk_frame(input string req, input int base, input bit is_wr,
                           input bit nopre, input logic [4:0] ph,
                           input logic [4:0] rg, input logic [15:0] wd);
    logic [1:0] e [0:63];
    logic [13:0] hdr;
    int n = 0;
    int bad = -1;
    if (!nopre) for (int i = 0; i < 32; i++) begin e[n] = 2'b01; n++; end
    hdr = {2'b01, (is_wr ? 2'b01 : 2'b10), ph, rg};
    for (int i = 13; i >= 0; i--) begin e[n] = {1'b0, hdr[i]}; n++; end
    if (is_wr) begin
      e[n] = 2'b01; n++; e[n] = 2'b00; n++;
      for (int i = 15; i >= 0; i--) begin e[n] = {1'b0, wd[i]}; n++; end
    end else begin
      for (int i = 0; i < 18; i++) begin e[n] = 2'b10; n++; end
    end
    chk((cap_n - base) == n, req, "frame bit count", cap_n - base, n);
    for (int i = 0; i < n; i++)
      if (bad < 0 && (base + i) < 4096 && cap[base+i] !== e[i]) bad = i;
    chk(bad < 0, req, "frame bit mismatch at index", bad, -1);
  endtask

  task automatic do_txn(input string req, input bit is_wr, input logic [4:0] ph,
                        input logic [4:0] rg, input logic [15:0] wd,
                        input bit nopre, input logic [7:0] dv);
    logic [31:0] s;
    int base;
    int halfc;
    halfc = (dv[7:1] == 0) ? 1 : int'(dv[7:1]);
    reg_write(3'd0, {23'b0, nopre, dv});
    reg_write(3'd2, {19'b0, rg, 3'b0, ph});
    reg_write(3'd3, {16'b0, wd});
    base = cap_n;
    reg_write(3'd1, is_wr ? 32'd4 : 32'd2);
    reg_read(3'd5, s);
    chk(s[1] == 1'b1, "R6", "busy after command", s[1], 1);
    wait_idle();
    chk_frame(req, base, is_wr, nopre, ph, rg, wd);
    chk(per == time'(10 * halfc), "R2", "MDC period ns", per, 10 * halfc);
    if (!is_wr) begin
      reg_read(3'd4, s);
      chk(s[15:0] == phy_val, "R3", "read data", s[15:0], phy_val);
    end
    chk(!mdc && !mdio_oe, "R10", "idle pins", {mdc, mdio_oe}, 0);
    reg_write(3'd1, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int base, seed, rc;
    errs = 0; checks = 0; cap_n = 0; last_rise = 0; per = 0; rel = 0;
    phy_val = 16'h0; mdio_in = 1'b1;
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    seed = $urandom(32'h5eed);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      reg_read(3'(a), s);
      chk(s == 32'd0, "R1", "register after reset", s, 0);
    end
    chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);

    // R2 odd divisor forced even
    reg_write(3'd0, 32'd9);
    reg_read(3'd0, s);
    chk(s == 32'd8, "R2", "divisor readback", s, 8);

    // R3 directed read, divisor 8
    phy_val = 16'hA5C3;
    do_txn("R3", 1'b0, 5'h11, 5'h02, 16'h0, 1'b0, 8'd8);
    rc = cap_n; idle_cycles(100);
    chk(cap_n == rc, "R7", "clear command starts nothing", cap_n, rc);

    // R7 rewrite of an already set bit
    reg_write(3'd1, 32'd2);
    wait_idle();
    rc = cap_n;
    reg_write(3'd1, 32'd2);
    idle_cycles(100);
    chk(cap_n == rc, "R7", "rewrite set bit starts nothing", cap_n, rc);
    reg_write(3'd1, 32'd0);

    // R4 + R5 write without preamble
    do_txn("R5", 1'b1, 5'h1E, 5'h15, 16'h3C5A, 1'b1, 8'd4);
    do_txn("R4", 1'b1, 5'h03, 5'h10, 16'h8001, 1'b0, 8'd2);

    // R7 new bit set while busy is ignored
    phy_val = 16'h1234;
    reg_write(3'd0, 32'd4);
    base = cap_n;
    reg_write(3'd1, 32'd2);
    idle_cycles(20);
    reg_write(3'd1, 32'd6);
    wait_idle();
    idle_cycles(100);
    chk(cap_n - base == 64, "R7", "command while busy ignored", cap_n - base, 64);
    reg_write(3'd1, 32'd0);

    // R8 priority write over read
    reg_write(3'd3, 32'h0000BEEF);
    reg_write(3'd2, 32'h00000905);
    base = cap_n;
    reg_write(3'd1, 32'd6);
    wait_idle();
    chk_frame("R8", base, 1'b1, 1'b0, 5'h05, 5'h09, 16'hBEEF);
    reg_write(3'd1, 32'd0);
    // read over scan
    phy_val = 16'h0F0F;
    base = cap_n;
    reg_write(3'd1, 32'd3);
    wait_idle();
    idle_cycles(100);
    chk_frame("R8", base, 1'b0, 1'b0, 5'h05, 5'h09, 16'h0);
    reg_read(3'd5, s);
    chk(s[2:0] == 3'b000, "R8", "scan lost to read, status", s[2:0], 0);
    reg_write(3'd1, 32'd0);

    // R2 divisor zero behaves as two
    phy_val = 16'h00FF;
    do_txn("R2", 1'b0, 5'h00, 5'h1F, 16'h0, 1'b0, 8'd0);

    // R9 scan
    phy_val = 16'h7FF9;
    reg_write(3'd0, 32'd2);
    reg_write(3'd2, 32'h00000101);
    reg_write(3'd1, 32'd1);
    reg_read(3'd5, s);
    chk(s[2:1] == 2'b11, "R9", "invalid and busy at scan start", s[2:0], 6);
    for (int i = 0; i < 30000; i++) begin
      reg_read(3'd5, s);
      if (!s[2]) break;
    end
    chk(s[2:0] == 3'b011, "R9", "status after first scan", s[2:0], 3);
    reg_read(3'd4, s);
    chk(s[15:0] == 16'h7FF9, "R9", "scan data", s[15:0], 16'h7FF9);
    phy_val = 16'h0004;
    rc = cap_n + 64;
    for (int i = 0; i < 30000 && cap_n < rc; i++) @(negedge clk);
    idle_cycles(6);
    reg_read(3'd5, s);
    chk(s[0] == 1'b0 && s[1] == 1'b1, "R9", "link ok while scanning", s[2:0], 2);
    reg_write(3'd1, 32'd0);
    wait_idle();
    rc = cap_n;
    idle_cycles(200);
    chk(cap_n == rc, "R9", "scan stopped", cap_n, rc);

    // random mix
    for (int t = 0; t < 12; t++) begin
      logic [4:0] ph, rg;
      logic [15:0] wd;
      bit wr, np;
      logic [7:0] dv;
      wr = 1'($urandom % 2);
      np = 1'($urandom % 2);
      ph = 5'($urandom); rg = 5'($urandom); wd = 16'($urandom);
      dv = 8'(2 * (1 + ($urandom % 4)));
      phy_val = 16'($urandom);
      do_txn(wr ? "R4" : "R3", wr, ph, rg, wd, np, dv);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule